// File: doc/BRIEF.md
# Display Power Sequencing Controller

This block brings a display output path up and down in a fixed order. The path has four stages: pixel clock, synchronization timing, display enable and backlight PWM. Software requests a stage change by pulsing a write strobe with a one-hot bit mask. It then polls a live status vector until the change has taken effect. Each stage is modelled by its own acknowledge latency, a fixed number of cycles per stage. The block drives one enable line per stage towards the real timing and pixel logic.

The block enforces the dependencies between the stages. A stage cannot start until the stage it depends on is fully on. The sync stage cannot be shut down while the display stage is still up, and the clock cannot be shut down while sync is still up. A guard time counted in frames separates the sync and display stages in both directions. When the PWM stage is shut down, the block can hold the shutdown until the frame fetch reports completion, unless a no-wait option is given with the request.

Top module: `disp_pwrseq`

## Requirements
- R1: While `rst_n` is low at a clock edge, all status bits and all stage drive lines are 0 after that edge.
- R2: Bit positions in `en_bits`, `dis_bits`, `status` and `stage_drive` are: bit 0 pixel clock, bit 1 sync, bit 2 display, bit 3 PWM. A zero bit in a write leaves that stage unchanged, and a write with no bits set changes nothing.
- R3: An accepted enable raises the stage's drive line at the accepting edge. Its status bit rises exactly the stage latency in cycles later (default latencies: clock 3, sync 2, display 2, PWM 4) when nothing holds it.
- R4: Enabling sync, display or PWM is ignored unless its predecessor (clock, sync or display respectively) is fully on.
- R5: An accepted display enable first waits for `guard_frames` pulses on `frame_tick`, counted after the accepting edge, and then runs its latency. A guard value of 0 adds no wait.
- R6: Disabling sync is ignored while the display status is 1, and disabling the clock is ignored while the sync status is 1. Display and PWM disables need no precondition.
- R7: An accepted sync disable waits for `guard_frames` frame ticks before its status drops.
- R8: An accepted PWM disable with `dis_nowait` = 0 holds its status at 1 until a `dma_done` pulse arrives after the accepting edge. With `dis_nowait` = 1, the status drops after the latency alone.
- R9: A request is ignored for a stage that is already in the requested state or is in transition. A stage named in both `en_bits` and `dis_bits` in the same cycle is left unchanged.
- R10: An accepted disable drops the drive line at the accepting edge. The status bit drops after the stage latency plus any hold, so status stays 1 while the stage is winding down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr | input | 1 | Enable-register write strobe |
| en_bits | input | 4 | One-hot enable mask |
| dis_wr | input | 1 | Disable-register write strobe |
| dis_bits | input | 4 | One-hot disable mask |
| dis_nowait | input | 1 | With a PWM disable: skip the fetch-done wait |
| guard_frames | input | GUARD_W | Guard time in frames between sync and display |
| frame_tick | input | 1 | One pulse per frame |
| dma_done | input | 1 | Frame fetch completion pulse |
| stage_drive | output | 4 | Enable line to each stage |
| status | output | 4 | Live stage-active bits |

## Verification
The assertions assume that `frame_tick` and `dma_done` are single-cycle pulses. They also assume that `guard_frames` holds still while a guarded transition is pending. A third assumption is that software does not pull the display down while PWM is still rising. The stimulus meets these assumptions by changing `guard_frames` only while every stage is idle, by emitting each pulse for exactly one cycle, and by issuing every request only after the previous stage has settled. The illegal-order, conflicting and redundant requests are applied only when no other transition is pending, so that the absence of a change can be seen on the status port.

// File: rtl/pwrseq_pkg.sv
// Package: shared stage indices and the per-stage state type.
// Assumes four stages in power-up order clock, sync, display, PWM.
package pwrseq_pkg;
    localparam int NSTAGE   = 4;
    localparam int STG_CLK  = 0;
    localparam int STG_SYNC = 1;
    localparam int STG_DISP = 2;
    localparam int STG_PWM  = 3;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_UP   = 2'd1,
        ST_ON   = 2'd2,
        ST_DOWN = 2'd3
    } stage_st_t;
endpackage

// File: rtl/pwrseq_guard.sv
// Frame guard counter: on start it latches the guard value and counts
// frame ticks. It reports done once the count reaches the guard value.
// Assumes tick is a one-cycle pulse; a tick in the start cycle is not counted.
module pwrseq_guard #(
    parameter int GUARD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               tick,
    input  logic [GUARD_W-1:0] guard_in,
    output logic               done
);
    logic               running;
    logic [GUARD_W-1:0] cnt;
    logic [GUARD_W-1:0] guard_q;

    // Arm on start, then count frame ticks up to the latched guard value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            guard_q <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
            guard_q <= guard_in;
        end else if (running && tick && (cnt != guard_q)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Done is a level that lasts until the next start.
    always_comb done = running && (cnt == guard_q);

    p_guard_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= guard_q);
    p_guard_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt == '0));
endmodule

// File: rtl/pwrseq_stage.sv
// One sequenced stage: off, rising, on, falling. A transition counts LAT
// cycles while its hold input is low and then settles. Assumes the parent
// only raises req_on in the off state and req_off in the on state.
module pwrseq_stage
    import pwrseq_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_on,
    input  logic req_off,
    input  logic hold_up,
    input  logic hold_dn,
    output logic drive,
    output logic active,
    output logic is_on,
    output logic is_off
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(LAT - 1);

    stage_st_t      st;
    logic [CW-1:0]  cnt;

    // Stage state machine with the acknowledge latency counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_OFF;
            cnt <= '0;
        end else begin
            case (st)
                ST_OFF:  if (req_on)  begin st <= ST_UP;   cnt <= '0; end
                ST_ON:   if (req_off) begin st <= ST_DOWN; cnt <= '0; end
                ST_UP:   if (!hold_up) begin
                             if (cnt == LAST) st <= ST_ON;
                             else             cnt <= cnt + 1'b1;
                         end
                default: if (!hold_dn) begin
                             if (cnt == LAST) st <= ST_OFF;
                             else             cnt <= cnt + 1'b1;
                         end
            endcase
        end
    end

    // Decode drive (requested on) and status (physically active).
    always_comb begin
        drive  = (st == ST_UP) || (st == ST_ON);
        active = (st == ST_ON) || (st == ST_DOWN);
        is_on  = (st == ST_ON);
        is_off = (st == ST_OFF);
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_rise_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ($past(st) == ST_UP) && !$past(hold_up));
    p_fall_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> ($past(st) == ST_DOWN) && !$past(hold_dn));
endmodule

// File: rtl/disp_pwrseq.sv
// Display power sequencer top. It screens enable and disable requests
// against the stage order, drives the four stage instances, and gates
// the guarded and the fetch-dependent transitions. Assumes frame_tick and
// dma_done are one-cycle pulses and guard_frames is steady while in use.
module disp_pwrseq
    import pwrseq_pkg::*;
#(
    parameter int CLK_LAT  = 3,
    parameter int SYNC_LAT = 2,
    parameter int DISP_LAT = 2,
    parameter int PWM_LAT  = 4,
    parameter int GUARD_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_wr,
    input  logic [3:0]         en_bits,
    input  logic               dis_wr,
    input  logic [3:0]         dis_bits,
    input  logic               dis_nowait,
    input  logic [GUARD_W-1:0] guard_frames,
    input  logic               frame_tick,
    input  logic               dma_done,
    output logic [3:0]         stage_drive,
    output logic [3:0]         status
);
    logic [NSTAGE-1:0] en_req, dis_req, clash, en_ok, dis_ok;
    logic [NSTAGE-1:0] on_req, off_req, hold_up, hold_dn;
    logic [NSTAGE-1:0] st_on, st_off;
    logic              guard_start, guard_done;
    logic              nowait_q, dma_seen;

    // Mask the strobes and drop stages named in both masks.
    always_comb begin
        en_req  = en_wr  ? en_bits  : '0;
        dis_req = dis_wr ? dis_bits : '0;
        clash   = en_req & dis_req;
        en_ok   = en_req & ~clash;
        dis_ok  = dis_req & ~clash;
    end

    // Accept enables only in order, disables only once dependents are off.
    always_comb begin
        on_req[STG_CLK]   = en_ok[STG_CLK]  && st_off[STG_CLK];
        on_req[STG_SYNC]  = en_ok[STG_SYNC] && st_off[STG_SYNC] && st_on[STG_CLK];
        on_req[STG_DISP]  = en_ok[STG_DISP] && st_off[STG_DISP] && st_on[STG_SYNC];
        on_req[STG_PWM]   = en_ok[STG_PWM]  && st_off[STG_PWM]  && st_on[STG_DISP];
        off_req[STG_DISP] = dis_ok[STG_DISP] && st_on[STG_DISP];
        off_req[STG_SYNC] = dis_ok[STG_SYNC] && st_on[STG_SYNC] && st_off[STG_DISP];
        off_req[STG_CLK]  = dis_ok[STG_CLK]  && st_on[STG_CLK]  && st_off[STG_SYNC];
        off_req[STG_PWM]  = dis_ok[STG_PWM]  && st_on[STG_PWM];
        guard_start       = on_req[STG_DISP] || off_req[STG_SYNC];
    end

    // Latch the PWM stop mode and record fetch completion after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nowait_q <= 1'b0;
            dma_seen <= 1'b0;
        end else if (off_req[STG_PWM]) begin
            nowait_q <= dis_nowait;
            dma_seen <= 1'b0;
        end else if (dma_done) begin
            dma_seen <= 1'b1;
        end
    end

    // Per-stage holds: guard on display-up and sync-down, fetch on PWM-down.
    always_comb begin
        hold_up          = '0;
        hold_dn          = '0;
        hold_up[STG_DISP] = !guard_done;
        hold_dn[STG_SYNC] = !guard_done;
        hold_dn[STG_PWM]  = !(nowait_q || dma_seen);
    end

    pwrseq_guard #(.GUARD_W(GUARD_W)) guard_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (guard_start),
        .tick     (frame_tick),
        .guard_in (guard_frames),
        .done     (guard_done)
    );

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        localparam int LAT = (i == STG_CLK)  ? CLK_LAT  :
                             (i == STG_SYNC) ? SYNC_LAT :
                             (i == STG_DISP) ? DISP_LAT : PWM_LAT;
        pwrseq_stage #(.LAT(LAT)) stage_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_on  (on_req[i]),
            .req_off (off_req[i]),
            .hold_up (hold_up[i]),
            .hold_dn (hold_dn[i]),
            .drive   (stage_drive[i]),
            .active  (status[i]),
            .is_on   (st_on[i]),
            .is_off  (st_off[i])
        );
        if (i > 0) begin : g_order
            p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(stage_drive[i]) |-> $past(status[i-1]));
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (status == 4'b0) && (stage_drive == 4'b0));
    p_sync_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[STG_SYNC]) |-> !status[STG_DISP]);
    p_clk_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[STG_CLK]) |-> !status[STG_SYNC]);
    p_disp_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[STG_DISP]) |-> guard_done);
    p_sync_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[STG_SYNC]) |-> guard_done);
    p_pwm_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[STG_PWM]) |-> ($past(nowait_q) || $past(dma_seen)));
endmodule

// File: tb/disp_pwrseq_tb_top.sv
`timescale 1ns/1ps
module disp_pwrseq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_wr = 1'b0, dis_wr = 1'b0, dis_nowait = 1'b0;
    logic [3:0] en_bits = '0, dis_bits = '0;
    logic [3:0] guard_frames = '0;
    logic       frame_tick = 1'b0, dma_done = 1'b0;
    logic [3:0] stage_drive, status;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    typedef struct {
        string      tag;
        logic [3:0] exp_st;
        logic [3:0] exp_drv;
        bit         use_drv;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    disp_pwrseq dut_i (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_bits(en_bits),
        .dis_wr(dis_wr), .dis_bits(dis_bits), .dis_nowait(dis_nowait),
        .guard_frames(guard_frames), .frame_tick(frame_tick),
        .dma_done(dma_done), .stage_drive(stage_drive), .status(status)
    );

    // Monitor: pop expected items at the falling edge and compare.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (status !== e.exp_st || (e.use_drv && stage_drive !== e.exp_drv)) begin
                    errors++;
                    $display("FAIL %s: status=%b drive=%b expected status=%b drive=%b",
                             e.tag, status, stage_drive, e.exp_st, e.exp_drv);
                end
            end
        end
    end

    task automatic push_st(string tag, logic [3:0] st);
        exp_q.push_back('{tag, st, 4'b0, 1'b0});
    endtask

    task automatic push_both(string tag, logic [3:0] st, logic [3:0] drv);
        exp_q.push_back('{tag, st, drv, 1'b1});
    endtask

    task automatic check_num(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick_cycles(int n);
        for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
    endtask

    task automatic wr_en(logic [3:0] b);
        en_wr = 1'b1; en_bits = b;
        @(posedge clk); #1;
        en_wr = 1'b0; en_bits = '0;
    endtask

    task automatic wr_dis(logic [3:0] b, logic nw);
        dis_wr = 1'b1; dis_bits = b; dis_nowait = nw;
        @(posedge clk); #1;
        dis_wr = 1'b0; dis_bits = '0; dis_nowait = 1'b0;
    endtask

    task automatic pulse_tick();
        frame_tick = 1'b1; @(posedge clk); #1; frame_tick = 1'b0; tick_cycles(2);
    endtask

    // Count cycles until a status bit reaches a value (bounded).
    task automatic wait_bit(int idx, logic val, output int n);
        n = 0;
        while (status[idx] !== val && n < 200) begin
            @(posedge clk); #1; n++;
        end
    endtask

    initial begin
        int n;
        tick_cycles(3);
        rst_n = 1'b1;
        #0;
        // R1: reset state (sampled while still in reset, then released)
        push_both("R1 reset", 4'b0000, 4'b0000);
        tick_cycles(1);

        // R4: sync enable without clock is ignored
        wr_en(4'b0010); tick_cycles(6);
        push_both("R4 sync without clock", 4'b0000, 4'b0000);

        // R3: clock enable latency, drive at accept
        wr_en(4'b0001);
        push_both("R3 clock drive at accept", 4'b0000, 4'b0001);
        wait_bit(0, 1'b1, n);
        check_num("R3 clock latency", n, 3);
        push_st("R3 clock on", 4'b0001);

        // R2: empty write changes nothing
        wr_en(4'b0000); tick_cycles(5);
        push_both("R2 zero mask", 4'b0001, 4'b0001);

        // R4: display enable without sync is ignored
        wr_en(4'b0100); tick_cycles(6);
        push_both("R4 display without sync", 4'b0001, 4'b0001);

        // R3: sync enable latency
        wr_en(4'b0010);
        wait_bit(1, 1'b1, n);
        check_num("R3 sync latency", n, 2);
        push_st("R3 sync on", 4'b0011);

        // R6: clock disable while sync on is ignored
        wr_dis(4'b0001, 1'b0); tick_cycles(6);
        push_both("R6 clock off blocked", 4'b0011, 4'b0011);

        // R9: enabling an already-on stage is ignored
        wr_en(4'b0001); tick_cycles(4);
        push_both("R9 redundant enable", 4'b0011, 4'b0011);

        // R5: display waits two frames
        guard_frames = 4'd2;
        wr_en(4'b0100); tick_cycles(8);
        push_both("R5 display held by guard", 4'b0011, 4'b0111);
        pulse_tick();
        tick_cycles(4);
        push_st("R5 display after one frame", 4'b0011);
        pulse_tick();
        wait_bit(2, 1'b1, n);
        check_num("R5 display rose after guard", (n < 10) ? 1 : 0, 1);
        push_st("R5 display on", 4'b0111);

        // R3: PWM enable latency
        wr_en(4'b1000);
        wait_bit(3, 1'b1, n);
        check_num("R3 pwm latency", n, 4);
        push_st("R3 pwm on", 4'b1111);

        // R9: same stage in both masks is left alone
        en_wr = 1'b1; en_bits = 4'b0100; dis_wr = 1'b1; dis_bits = 4'b0100;
        @(posedge clk); #1;
        en_wr = 1'b0; en_bits = '0; dis_wr = 1'b0; dis_bits = '0;
        tick_cycles(5);
        push_both("R9 clash ignored", 4'b1111, 4'b1111);

        // R6: sync disable while display on is ignored
        wr_dis(4'b0010, 1'b0); tick_cycles(6);
        push_st("R6 sync off blocked", 4'b1111);

        // R10: display disable drops drive, status lingers
        wr_dis(4'b0100, 1'b0);
        push_both("R10 display winding down", 4'b1111, 4'b1011);
        wait_bit(2, 1'b0, n);
        check_num("R10 display off latency", n, 2);
        push_st("R10 display off", 4'b1011);

        // R7: sync disable waits for guard
        wr_dis(4'b0010, 1'b0); tick_cycles(8);
        push_both("R7 sync held by guard", 4'b1011, 4'b1001);
        pulse_tick(); pulse_tick();
        wait_bit(1, 1'b0, n);
        push_st("R7 sync off after guard", 4'b1001);

        // R8: PWM stop waits for fetch done
        wr_dis(4'b1000, 1'b0); tick_cycles(10);
        push_st("R8 pwm held by fetch", 4'b1001);
        dma_done = 1'b1; @(posedge clk); #1; dma_done = 1'b0;
        wait_bit(3, 1'b0, n);
        check_num("R8 pwm fell after fetch", (n < 10) ? 1 : 0, 1);
        push_st("R8 pwm off", 4'b0001);

        // R6: clock disable once sync off
        wr_dis(4'b0001, 1'b0);
        wait_bit(0, 1'b0, n);
        check_num("R6 clock off latency", n, 3);
        push_both("R6 all off", 4'b0000, 4'b0000);

        // R5: zero guard, bring up again
        guard_frames = 4'd0;
        wr_en(4'b0001); wait_bit(0, 1'b1, n);
        wr_en(4'b0010); wait_bit(1, 1'b1, n);
        wr_en(4'b0100); wait_bit(2, 1'b1, n);
        check_num("R5 zero guard display latency", n, 2);
        wr_en(4'b1000); wait_bit(3, 1'b1, n);
        push_st("R2 full stack on", 4'b1111);

        // R8: no-wait PWM stop
        wr_dis(4'b1000, 1'b1);
        wait_bit(3, 1'b0, n);
        check_num("R8 nowait pwm latency", n, 4);
        push_st("R8 nowait pwm off", 4'b0111);

        tick_cycles(3);
        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule